// File: doc/BRIEF.md
# Host-Firmware Ownership Mailbox

This block is a shared mailbox between a host bus master and an embedded firmware processor. Both sides must hold the mailbox before they may use its data words. A three-state owner register records who holds it: free, firmware or host. Each side claims it by presenting its own code. A claim lands only while the mailbox is free, so a side that loses the race sees a different owner code when it reads the register back. Either side can give the mailbox back.

The host sees a 32-bit register port. Writes take one clock and reads are combinational from the address. Through this port the host reaches five registers. The host places a request word in the inbound register. It then rings the firmware by setting the global enable and the firmware-interrupt enable in the command register. The block answers with a one-cycle firmware interrupt and a snapshot of the inbound word on the firmware port.

The firmware answers by posting an outbound word. If the SMI enable is set in the command register, the post raises a level interrupt toward the host. The firmware can also flag a hang, which raises the same interrupt. The host acknowledges both by writing ones back to the status register. Every message word packs an 8-bit type above a 24-bit payload. The block classifies the type of the outbound word for the host.

Top module: `hfw_mailbox`

## Requirements
- R1: After reset the owner code is 0 (free), the command and status registers read 0, and fw_irq, host_irq and fw_in_valid are low.
- R2: A host write of code 2 to the owner register (offset 0x0F0, bits 1:0) takes the mailbox only while it is free. A host write of code 1 or 3 changes nothing. The owner code never reads 3.
- R3: A firmware claim (fw_claim) takes the mailbox (code 1) only while it is free. When the host claim and the firmware claim arrive in the same cycle on a free mailbox, the firmware wins.
- R4: A host write of code 0 to the owner register frees the mailbox from any state, and it takes precedence over a claim in the same cycle. fw_release frees the mailbox only while the firmware holds it.
- R5: The inbound data register (offset 0x0E8) accepts host writes only while the host holds the mailbox. Otherwise it keeps its value, and the value survives a release.
- R6: The command register (offset 0x0E4) is writable in any owner state. It keeps only bits 31 (global enable), 30 (host-interrupt enable), 29 (SMI enable), 28 and 27 (firmware-interrupt enable). Its other bits read 0.
- R7: A host write to the command register with bits 31 and 27 both set, while the host holds the mailbox, makes fw_irq high for exactly the following cycle. On that edge the inbound word is also captured on fw_in_word and fw_in_valid is raised. No other write pulses fw_irq. Later inbound writes do not change the captured word. fw_in_valid is low whenever the mailbox is free.
- R8: fw_post stores fw_post_word in the outbound register (offset 0x0EC) only while the firmware holds the mailbox. Host writes to that offset have no effect.
- R9: An accepted post sets status bit 3 (offset 0x428) if command bit 29 is set, and leaves status unchanged if it is clear. fw_hang sets status bit 1. host_irq is high exactly while a status bit is set.
- R10: A host write to the status register clears each bit written as 1 and keeps the others. A set in the same cycle wins over the clear.
- R11: host_msg_kind classifies outbound bits 31:24: 1 to 15 give 1 (request), 128 gives 2 (ACK), 129 gives 3 (NAK), and any other value gives 0 (invalid).
- R12: Offsets outside the five registers read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr_en | input | 1 | Host register write strobe |
| hst_addr | input | ADDR_W | Host register byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for hst_addr |
| fw_claim | input | 1 | Firmware claims the mailbox |
| fw_release | input | 1 | Firmware gives the mailbox back |
| fw_post | input | 1 | Firmware posts an outbound word |
| fw_post_word | input | 32 | Outbound word from firmware |
| fw_hang | input | 1 | Firmware hang indication |
| owner_state | output | 2 | Current owner code |
| fw_irq | output | 1 | One-cycle interrupt to firmware |
| fw_in_valid | output | 1 | Captured inbound word is valid |
| fw_in_word | output | 32 | Captured inbound word |
| host_irq | output | 1 | Level interrupt to host |
| host_msg_kind | output | 2 | Class of the outbound message type |

## Verification
The bench targets the races on the owner register: claims from both sides in one cycle, a release that meets a claim, and claims against a held mailbox. A wrong priority there would hand the mailbox to two owners, or would let the host's read-back agree when it should not. It also checks that the doorbell needs both enable bits and host ownership, that the captured inbound word stays fixed after later writes, and that a clear landing with a new hang keeps the status bit. A design that got these wrong would ring firmware spuriously or lose a host interrupt. The edges of the type classification (15, 16, 0, 128, 129) are probed so that an off-by-one range test shows up.

// File: rtl/hfw_mbox_pkg.sv
package hfw_mbox_pkg;

  localparam int MSG_W  = 32;
  localparam int TYPE_W = 8;
  localparam int PAY_W  = MSG_W - TYPE_W;
  localparam int OWN_W  = 2;

  localparam logic [OWN_W-1:0] OWN_FREE = 2'd0;
  localparam logic [OWN_W-1:0] OWN_FW   = 2'd1;
  localparam logic [OWN_W-1:0] OWN_HOST = 2'd2;

  localparam logic [1:0] KIND_INVALID = 2'd0;
  localparam logic [1:0] KIND_REQ     = 2'd1;
  localparam logic [1:0] KIND_ACK     = 2'd2;
  localparam logic [1:0] KIND_NAK     = 2'd3;

  localparam logic [TYPE_W-1:0] TYPE_REQ_LO = 8'd1;
  localparam logic [TYPE_W-1:0] TYPE_REQ_HI = 8'd15;
  localparam logic [TYPE_W-1:0] TYPE_ACK    = 8'd128;
  localparam logic [TYPE_W-1:0] TYPE_NAK    = 8'd129;

  // command register bit positions
  localparam int CB_GLOBAL = 31;
  localparam int CB_HOST   = 30;
  localparam int CB_SMI    = 29;
  localparam int CB_PME    = 28;
  localparam int CB_FW     = 27;
  localparam logic [MSG_W-1:0] CMD_KEEP = (MSG_W'(1) << CB_GLOBAL) | (MSG_W'(1) << CB_HOST) |
                                          (MSG_W'(1) << CB_SMI) | (MSG_W'(1) << CB_PME) |
                                          (MSG_W'(1) << CB_FW);

  // status bits: index 0 -> hang, index 1 -> message pending
  localparam int ST_N = 2;
  localparam int ST_POS [ST_N] = '{1, 3};

  localparam logic [11:0] OFS_CMD  = 12'h0E4;
  localparam logic [11:0] OFS_DIN  = 12'h0E8;
  localparam logic [11:0] OFS_DOUT = 12'h0EC;
  localparam logic [11:0] OFS_OWN  = 12'h0F0;
  localparam logic [11:0] OFS_STAT = 12'h428;

  function automatic logic [1:0] classify(input logic [TYPE_W-1:0] t);
    logic [1:0] k;
    if (t >= TYPE_REQ_LO && t <= TYPE_REQ_HI) k = KIND_REQ;
    else if (t == TYPE_ACK)                    k = KIND_ACK;
    else if (t == TYPE_NAK)                    k = KIND_NAK;
    else                                       k = KIND_INVALID;
    return k;
  endfunction

endpackage

// File: rtl/hfw_owner_arb.sv
module hfw_owner_arb
  import hfw_mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_set_i,
  input  logic [OWN_W-1:0] host_code_i,
  input  logic             fw_claim_i,
  input  logic             fw_release_i,
  output logic [OWN_W-1:0] owner_o
);

  logic [OWN_W-1:0] owner_q, owner_d;
  logic             owner_en;

  always_comb begin
    owner_d = owner_q;
    if (host_set_i && host_code_i == OWN_FREE) begin
      owner_d = OWN_FREE;
    end else if (owner_q == OWN_FREE) begin
      if (fw_claim_i)                                  owner_d = OWN_FW;
      else if (host_set_i && host_code_i == OWN_HOST)  owner_d = OWN_HOST;
    end else if (owner_q == OWN_FW && fw_release_i) begin
      owner_d = OWN_FREE;
    end
  end

  assign owner_en = (owner_d != owner_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owner_q <= OWN_FREE;
    else if (owner_en) owner_q <= owner_d;
  end

  assign owner_o = owner_q;

endmodule

// File: rtl/hfw_doorbell.sv
module hfw_doorbell #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ring_i,
  input  logic [W-1:0] word_i,
  input  logic         free_i,
  output logic         irq_o,
  output logic         valid_o,
  output logic [W-1:0] word_o
);

  logic         irq_q, irq_d;
  logic         val_q, val_d;
  logic [W-1:0] word_q;

  always_comb begin
    irq_d = ring_i;
    val_d = val_q;
    if (ring_i)      val_d = 1'b1;
    else if (free_i) val_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      val_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      val_q <= val_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (ring_i) word_q <= word_i;
  end

  assign irq_o   = irq_q;
  assign valid_o = val_q & ~free_i;
  assign word_o  = word_q;

endmodule

// File: rtl/hfw_smi_status.sv
module hfw_smi_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);

  logic [N-1:0] st_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_d;
    always_comb begin
      bit_d = st_q[g];
      if (clr_wr_i && clr_mask_i[g]) bit_d = 1'b0;
      if (set_i[g])                  bit_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= 1'b0;
      else        st_q[g] <= bit_d;
    end
  end

  assign status_o = st_q;
  assign irq_o    = |st_q;

endmodule

// File: rtl/hfw_mailbox.sv
module hfw_mailbox
  import hfw_mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr_en,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  input  logic              fw_claim,
  input  logic              fw_release,
  input  logic              fw_post,
  input  logic [31:0]       fw_post_word,
  input  logic              fw_hang,
  output logic [1:0]        owner_state,
  output logic              fw_irq,
  output logic              fw_in_valid,
  output logic [31:0]       fw_in_word,
  output logic              host_irq,
  output logic [1:0]        host_msg_kind
);

  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFS_DIN);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFS_DOUT);
  localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic [OWN_W-1:0] owner;
  logic wr_cmd, wr_din, wr_own, wr_stat;
  logic din_en, dout_en, ring;
  logic [MSG_W-1:0] cmd_q, cmd_d, din_q, dout_q;
  logic [ST_N-1:0]  st_set, st_clr, st_bits;
  logic [MSG_W-1:0] st_word;

  assign wr_cmd  = hst_wr_en && (hst_addr == A_CMD);
  assign wr_din  = hst_wr_en && (hst_addr == A_DIN);
  assign wr_own  = hst_wr_en && (hst_addr == A_OWN);
  assign wr_stat = hst_wr_en && (hst_addr == A_STAT);

  hfw_owner_arb u_owner (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_set_i   (wr_own),
    .host_code_i  (hst_wdata[OWN_W-1:0]),
    .fw_claim_i   (fw_claim),
    .fw_release_i (fw_release),
    .owner_o      (owner)
  );

  // command register
  assign cmd_d = hst_wdata & CMD_KEEP;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (wr_cmd) cmd_q <= cmd_d;
  end

  // data words, each gated by ownership
  assign din_en  = wr_din && (owner == OWN_HOST);
  assign dout_en = fw_post && (owner == OWN_FW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      din_q <= '0;
    else if (din_en) din_q <= hst_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (dout_en) dout_q <= fw_post_word;
  end

  // doorbell toward firmware
  assign ring = wr_cmd && (owner == OWN_HOST) && hst_wdata[CB_GLOBAL] && hst_wdata[CB_FW];

  hfw_doorbell #(.W(MSG_W)) u_bell (
    .clk     (clk),
    .rst_n   (rst_n),
    .ring_i  (ring),
    .word_i  (din_q),
    .free_i  (owner == OWN_FREE),
    .irq_o   (fw_irq),
    .valid_o (fw_in_valid),
    .word_o  (fw_in_word)
  );

  // status toward host
  assign st_set = {dout_en && cmd_q[CB_SMI], fw_hang};
  for (genvar s = 0; s < ST_N; s++) begin : g_stmap
    assign st_clr[s] = hst_wdata[ST_POS[s]];
  end

  hfw_smi_status #(.N(ST_N)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (st_set),
    .clr_wr_i   (wr_stat),
    .clr_mask_i (st_clr),
    .status_o   (st_bits),
    .irq_o      (host_irq)
  );

  always_comb begin
    st_word = '0;
    for (int s = 0; s < ST_N; s++) st_word[ST_POS[s]] = st_bits[s];
  end

  // host read mux
  always_comb begin
    hst_rdata = '0;
    unique case (hst_addr)
      A_CMD:   hst_rdata = cmd_q;
      A_DIN:   hst_rdata = din_q;
      A_DOUT:  hst_rdata = dout_q;
      A_OWN:   hst_rdata = {{(MSG_W-OWN_W){1'b0}}, owner};
      A_STAT:  hst_rdata = st_word;
      default: hst_rdata = '0;
    endcase
  end

  assign owner_state   = owner;
  assign host_msg_kind = classify(dout_q[MSG_W-1 -: TYPE_W]);

endmodule

// File: rtl/hfw_mailbox_chk.sv
module hfw_mailbox_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_wr_en,
  input logic [ADDR_W-1:0] hst_addr,
  input logic [1:0]        wd_own,
  input logic [1:0]        wd_ring,
  input logic              fw_claim,
  input logic              fw_release,
  input logic              fw_hang,
  input logic [1:0]        owner_state,
  input logic              fw_irq,
  input logic              fw_in_valid,
  input logic              host_irq
);

  logic w_own, w_cmd, h_rel, h_claim, ring_req;
  assign w_own    = hst_wr_en && (hst_addr == ADDR_W'(12'h0F0));
  assign w_cmd    = hst_wr_en && (hst_addr == ADDR_W'(12'h0E4));
  assign h_rel    = w_own && (wd_own == 2'd0);
  assign h_claim  = w_own && (wd_own == 2'd2);
  assign ring_req = w_cmd && (wd_ring == 2'b11) && (owner_state == 2'd2);

  p_owner_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    owner_state != 2'd3);

  p_host_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_state == 2'd0 && h_claim && !fw_claim) |=> owner_state == 2'd2);

  p_fw_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_state == 2'd0 && fw_claim && !h_rel) |=> owner_state == 2'd1);

  p_fw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_state == 2'd1 && !fw_release && !h_rel) |=> owner_state == 2'd1);

  p_host_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    h_rel |=> owner_state == 2'd0);

  p_doorbell_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ring_req |=> (fw_irq && fw_in_valid));

  p_no_stray_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !w_cmd |=> !fw_irq);

  p_hang_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fw_hang |=> host_irq);

endmodule

bind hfw_mailbox hfw_mailbox_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .hst_wr_en   (hst_wr_en),
  .hst_addr    (hst_addr),
  .wd_own      (hst_wdata[1:0]),
  .wd_ring     ({hst_wdata[31], hst_wdata[27]}),
  .fw_claim    (fw_claim),
  .fw_release  (fw_release),
  .fw_hang     (fw_hang),
  .owner_state (owner_state),
  .fw_irq      (fw_irq),
  .fw_in_valid (fw_in_valid),
  .host_irq    (host_irq)
);

// File: tb/hfw_mailbox_tb_top.sv
module hfw_mailbox_tb_top;

  localparam logic [11:0] A_CMD  = 12'h0E4;
  localparam logic [11:0] A_DIN  = 12'h0E8;
  localparam logic [11:0] A_DOUT = 12'h0EC;
  localparam logic [11:0] A_OWN  = 12'h0F0;
  localparam logic [11:0] A_STAT = 12'h428;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_OWN,  32'h0,        32'h0,        8'd1},  // R1
    '{1'b0, A_CMD,  32'h0,        32'h0,        8'd1},
    '{1'b0, A_STAT, 32'h0,        32'h0,        8'd1},
    '{1'b1, A_DIN,  32'h01234567, 32'h0,        8'd5},
    '{1'b0, A_DIN,  32'h0,        32'h0,        8'd5},  // R5 free: ignored
    '{1'b1, A_OWN,  32'h1,        32'h0,        8'd2},
    '{1'b0, A_OWN,  32'h0,        32'h0,        8'd2},  // R2 code 1 ignored
    '{1'b1, A_OWN,  32'h3,        32'h0,        8'd2},
    '{1'b0, A_OWN,  32'h0,        32'h0,        8'd2},  // R2 code 3 ignored
    '{1'b1, A_OWN,  32'h2,        32'h0,        8'd2},
    '{1'b0, A_OWN,  32'h0,        32'h2,        8'd2},
    '{1'b1, A_DIN,  32'h02ABCDEF, 32'h0,        8'd5},
    '{1'b0, A_DIN,  32'h0,        32'h02ABCDEF, 8'd5},
    '{1'b1, A_CMD,  32'hFFFFFFFF, 32'h0,        8'd6},
    '{1'b0, A_CMD,  32'h0,        32'hF8000000, 8'd6},  // R6 mask
    '{1'b1, A_CMD,  32'h00000000, 32'h0,        8'd6},
    '{1'b0, A_CMD,  32'h0,        32'h0,        8'd6},
    '{1'b1, A_DOUT, 32'hDEADBEEF, 32'h0,        8'd8},
    '{1'b0, A_DOUT, 32'h0,        32'h0,        8'd8},  // R8 host write ignored
    '{1'b1, 12'h100, 32'h5,       32'h0,        8'd12},
    '{1'b0, 12'h100, 32'h0,       32'h0,        8'd12}, // R12 unmapped
    '{1'b1, A_OWN,  32'h0,        32'h0,        8'd4},
    '{1'b0, A_OWN,  32'h0,        32'h0,        8'd4},  // R4 release
    '{1'b0, A_DIN,  32'h0,        32'h02ABCDEF, 8'd5}
  };

  logic        clk, rst_n;
  logic        hst_wr_en;
  logic [11:0] hst_addr;
  logic [31:0] hst_wdata, hst_rdata;
  logic        fw_claim, fw_release, fw_post, fw_hang;
  logic [31:0] fw_post_word;
  logic [1:0]  owner_state, host_msg_kind;
  logic        fw_irq, fw_in_valid, host_irq;
  logic [31:0] fw_in_word;

  int n_chk, n_err;
  bit done;

  hfw_mailbox #(.ADDR_W(12)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .hst_wr_en (hst_wr_en), .hst_addr (hst_addr), .hst_wdata (hst_wdata), .hst_rdata (hst_rdata),
    .fw_claim (fw_claim), .fw_release (fw_release), .fw_post (fw_post),
    .fw_post_word (fw_post_word), .fw_hang (fw_hang),
    .owner_state (owner_state), .fw_irq (fw_irq), .fw_in_valid (fw_in_valid),
    .fw_in_word (fw_in_word), .host_irq (host_irq), .host_msg_kind (host_msg_kind)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [11:0] a, input logic [31:0] d);
    hst_wr_en = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic hrd(input logic [11:0] a, output logic [31:0] r);
    hst_addr = a;
    #1;
    r = hst_rdata;
  endtask

  task automatic post(input logic [31:0] w);
    fw_post = 1'b1; fw_post_word = w;
    @(negedge clk);
    fw_post = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; hst_wr_en = 1'b0; hst_addr = '0; hst_wdata = '0;
    fw_claim = 1'b0; fw_release = 1'b0; fw_post = 1'b0; fw_post_word = '0; fw_hang = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 port reset state
    chk("R1 fw_irq", {31'b0, fw_irq}, 32'h0);
    chk("R1 host_irq", {31'b0, host_irq}, 32'h0);
    chk("R1 fw_in_valid", {31'b0, fw_in_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) hwr(VEC[i].addr, VEC[i].data);
      else begin
        hrd(VEC[i].addr, r);
        chk($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
      end
    end
    @(negedge clk);

    // R7 doorbell
    hwr(A_OWN, 32'h2);
    hwr(A_DIN, 32'h01000042);
    hwr(A_CMD, 32'h88000000);
    chk("R7 fw_irq pulse", {31'b0, fw_irq}, 32'h1);
    chk("R7 captured word", fw_in_word, 32'h01000042);
    chk("R7 valid", {31'b0, fw_in_valid}, 32'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'b0, fw_irq}, 32'h0);
    hwr(A_DIN, 32'h00000003);
    chk("R7 snapshot held", fw_in_word, 32'h01000042);
    hwr(A_CMD, 32'h80000000);
    chk("R7 no ring without bit27", {31'b0, fw_irq}, 32'h0);
    hwr(A_CMD, 32'h08000000);
    chk("R7 no ring without bit31", {31'b0, fw_irq}, 32'h0);
    hwr(A_OWN, 32'h0);
    chk("R7 valid low when free", {31'b0, fw_in_valid}, 32'h0);
    hwr(A_CMD, 32'h88000000);
    chk("R7 no ring when free", {31'b0, fw_irq}, 32'h0);
    hwr(A_CMD, 32'h0);

    // R3 firmware claim, R2 host blocked
    fw_claim = 1'b1; @(negedge clk); fw_claim = 1'b0;
    chk("R3 fw claim", {30'b0, owner_state}, 32'h1);
    hwr(A_OWN, 32'h2);
    chk("R2 host claim blocked", {30'b0, owner_state}, 32'h1);
    hwr(A_DIN, 32'h0000AAAA);
    hrd(A_DIN, r);
    chk("R5 write blocked under fw", r, 32'h00000003);
    @(negedge clk);

    // R8 / R11 / R9 posts
    post(32'h80000055);
    hrd(A_DOUT, r);
    chk("R8 post stored", r, 32'h80000055);
    chk("R11 ack kind", {30'b0, host_msg_kind}, 32'h2);
    chk("R9 no irq without smi", {31'b0, host_irq}, 32'h0);
    @(negedge clk);
    hwr(A_CMD, 32'h20000000);
    hrd(A_CMD, r);
    chk("R6 cmd write under fw", r, 32'h20000000);
    @(negedge clk);
    post(32'h81000001);
    chk("R9 host_irq on post", {31'b0, host_irq}, 32'h1);
    hrd(A_STAT, r);
    chk("R9 status msg bit", r, 32'h00000008);
    chk("R11 nak kind", {30'b0, host_msg_kind}, 32'h3);
    @(negedge clk);
    hwr(A_STAT, 32'h2);
    hrd(A_STAT, r);
    chk("R10 clear other bit keeps", r, 32'h00000008);
    @(negedge clk);
    hwr(A_STAT, 32'h8);
    hrd(A_STAT, r);
    chk("R10 w1c clears", r, 32'h0);
    chk("R9 host_irq drops", {31'b0, host_irq}, 32'h0);
    @(negedge clk);
    hwr(A_CMD, 32'h0);
    post(32'h0F000000);
    chk("R11 type 15 request", {30'b0, host_msg_kind}, 32'h1);
    post(32'h10000000);
    chk("R11 type 16 invalid", {30'b0, host_msg_kind}, 32'h0);
    post(32'h00FFFFFF);
    chk("R11 type 0 invalid", {30'b0, host_msg_kind}, 32'h0);
    post(32'h01000000);
    chk("R11 type 1 request", {30'b0, host_msg_kind}, 32'h1);
    chk("R9 no status when smi clear", {31'b0, host_irq}, 32'h0);

    // R9 hang, R10 set wins
    fw_hang = 1'b1; @(negedge clk); fw_hang = 1'b0;
    hrd(A_STAT, r);
    chk("R9 hang bit", r, 32'h00000002);
    chk("R9 hang irq", {31'b0, host_irq}, 32'h1);
    @(negedge clk);
    fw_hang = 1'b1;
    hwr(A_STAT, 32'h2);
    fw_hang = 1'b0;
    hrd(A_STAT, r);
    chk("R10 set wins over clear", r, 32'h00000002);
    @(negedge clk);
    hwr(A_STAT, 32'hFFFFFFFF);
    chk("R10 all cleared", {31'b0, host_irq}, 32'h0);

    // R4 releases
    fw_release = 1'b1; @(negedge clk); fw_release = 1'b0;
    chk("R4 fw release", {30'b0, owner_state}, 32'h0);
    hwr(A_OWN, 32'h2);
    fw_release = 1'b1; @(negedge clk); fw_release = 1'b0;
    chk("R4 fw release ignored under host", {30'b0, owner_state}, 32'h2);
    fw_claim = 1'b1; @(negedge clk); fw_claim = 1'b0;
    chk("R3 fw claim blocked under host", {30'b0, owner_state}, 32'h2);
    post(32'h12345678);
    hrd(A_DOUT, r);
    chk("R8 post ignored under host", r, 32'h01000000);
    @(negedge clk);
    hwr(A_OWN, 32'h0);

    // same-cycle races
    fw_claim = 1'b1;
    hwr(A_OWN, 32'h2);
    fw_claim = 1'b0;
    chk("R3 fw wins tie", {30'b0, owner_state}, 32'h1);
    hwr(A_OWN, 32'h0);
    fw_claim = 1'b1;
    hwr(A_OWN, 32'h0);
    fw_claim = 1'b0;
    chk("R4 release beats claim", {30'b0, owner_state}, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule